// File: doc/BRIEF.md
# Accumulator ALU with Decimal Correction

This block keeps an 8-bit accumulator together with a five-bit status register holding sign, zero, half-carry (carry out of bit 3), parity and carry. Each cycle in which the strobe is high, it applies one operation to the accumulator. It uses the 8-bit operand input, the current flags, or both. The new accumulator and flags are registered on that clock edge. In any other cycle both registers keep their value.

The operation set has four groups. The first is binary arithmetic: add and subtract, each with or without the incoming carry, plus a compare that only changes the flags. The second is the three bitwise logic operations. The third is four one-bit rotates of the accumulator. The last covers three carry and complement operations and a decimal correction step that turns a binary sum of two packed BCD bytes into a valid BCD byte. Opcode decoding and operand sourcing belong to the surrounding datapath. This block only sees a 4-bit operation code and the operand byte.

Top module: `acc_alu_core`

## Requirements
- R1: While `rst_n` is low, `acc_q` is 0x00 and `flags_q` is 0b00000. `flags_q` bit order is {S, Z, AC, P, CY}: S is bit 4 and CY is bit 0.
- R2: Both registers update only on a rising clock edge where `op_valid` is 1. With `op_valid` at 0 they keep their value, whatever `op_code` and `operand` are.
- R3: `op_code` values are 0 ADD, 1 ADC, 2 SUB, 3 SBB, 4 AND, 5 XOR, 6 OR, 7 CMP, 8 RLC, 9 RRC, 10 RAL, 11 RAR, 12 DAA, 13 CMA, 14 STC, 15 CMC. ADD writes A+operand and ADC writes A+operand+CY, both modulo 256. CY is the carry out of bit 7 and AC is the carry out of bit 3.
- R4: SUB writes A-operand and SBB writes A-operand-CY, both modulo 256. CY is set when the true difference is negative. AC is set when the low nibble of A is less than the low nibble of the operand plus the borrow-in.
- R5: After ADD, ADC, SUB, SBB, AND, XOR, OR, CMP and DAA, S equals bit 7 of the 8-bit result. Z is 1 when that result is zero. P is 1 when the result has an even number of one bits.
- R6: CMP sets all five flags exactly as SUB would and leaves the accumulator unchanged.
- R7: AND, XOR and OR write the bitwise result and clear CY. AND sets AC, while XOR and OR clear AC.
- R8: RLC moves every bit up one place, and old bit 7 goes to both bit 0 and CY. RRC moves every bit down one place, and old bit 0 goes to both bit 7 and CY.
- R9: RAL shifts left with old CY into bit 0 and old bit 7 into CY. RAR shifts right with old CY into bit 7 and old bit 0 into CY.
- R10: The four rotates leave S, Z, AC and P unchanged.
- R11: DAA adds 0x06 when the low nibble of A is above 9 or AC is 1. It also adds 0x60 when A is above 0x99 or CY is 1. CY becomes 1 exactly when the 0x60 correction is applied, and AC becomes 1 exactly when the low nibble of A was above 9.
- R12: CMA inverts all accumulator bits and keeps every flag. STC sets CY to 1, and CMC inverts CY. Both keep the accumulator and the other four flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Apply the operation on this edge |
| op_code | input | 4 | Operation select, encoding in R3 |
| operand | input | 8 | Second operand for arithmetic, logic and compare |
| acc_q | output | 8 | Registered accumulator |
| flags_q | output | 5 | Registered flags {S, Z, AC, P, CY} |

## Verification
The bench uses the package's default 8-bit accumulator with 4-bit nibbles. At that width every operation can be driven from all 256 accumulator values. Each value is paired with five operand bytes and with all four combinations of incoming half-carry and carry, and these states are built through the block's own logic operations. Decimal correction is also driven right after add-with-carry of many BCD and non-BCD byte pairs. This covers the corner cases of R11: a low nibble above 9, a half-carry with a small nibble, a sum above 0x99, and the wrap through 0xFF.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int ACC_W  = 8;
  localparam int NIB_W  = ACC_W / 2;
  localparam int OP_W   = 4;
  localparam int FLAG_W = 5;

  typedef logic [ACC_W-1:0] word_t;
  typedef logic [NIB_W-1:0] nib_t;

  // packed order gives flags_q = {S, Z, AC, P, CY}
  typedef struct packed {
    logic s;
    logic z;
    logic ac;
    logic p;
    logic cy;
  } flags_t;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 4'd0,  OP_ADC = 4'd1,  OP_SUB = 4'd2,  OP_SBB = 4'd3,
    OP_AND = 4'd4,  OP_XOR = 4'd5,  OP_OR  = 4'd6,  OP_CMP = 4'd7,
    OP_RLC = 4'd8,  OP_RRC = 4'd9,  OP_RAL = 4'd10, OP_RAR = 4'd11,
    OP_DAA = 4'd12, OP_CMA = 4'd13, OP_STC = 4'd14, OP_CMC = 4'd15
  } op_e;

  localparam nib_t DEC_STEP = NIB_W'(6);
  localparam nib_t DEC_MAX  = NIB_W'(9);

  function automatic logic [ACC_W:0] wide_sum(word_t a, word_t b, logic ci);
    return {1'b0, a} + {1'b0, b} + {{ACC_W{1'b0}}, ci};
  endfunction

  function automatic logic [NIB_W:0] nib_sum(nib_t a, nib_t b, logic ci);
    return {1'b0, a} + {1'b0, b} + {{NIB_W{1'b0}}, ci};
  endfunction

  function automatic flags_t eval_flags(word_t r, logic ac, logic cy);
    flags_t f;
    f.s  = r[ACC_W-1];
    f.z  = (r == '0);
    f.ac = ac;
    f.p  = ~^r;
    f.cy = cy;
    return f;
  endfunction
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
  import acc_alu_pkg::*;
(
  input  word_t a_i,
  input  word_t b_i,
  input  logic  cy_i,
  input  logic  sub_i,
  input  logic  use_cy_i,
  output word_t res_o,
  output logic  cy_o,
  output logic  ac_o
);
  logic             ci_raw;
  logic             ci_eff;
  word_t            b_eff;
  logic [ACC_W:0]   full;
  logic [NIB_W:0]   low;

  // subtract as a + ~b + ~borrow; carry out inverted is the borrow
  assign ci_raw = use_cy_i & cy_i;
  assign ci_eff = sub_i ? ~ci_raw : ci_raw;
  assign b_eff  = sub_i ? ~b_i : b_i;
  assign full   = wide_sum(a_i, b_eff, ci_eff);
  assign low    = nib_sum(a_i[NIB_W-1:0], b_eff[NIB_W-1:0], ci_eff);

  assign res_o = full[ACC_W-1:0];
  assign cy_o  = full[ACC_W] ^ sub_i;
  assign ac_o  = low[NIB_W] ^ sub_i;
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise
  import acc_alu_pkg::*;
(
  input  op_e   op_i,
  input  word_t a_i,
  input  word_t b_i,
  input  logic  cy_i,
  output word_t res_o,
  output logic  cy_o
);
  word_t rot_l;
  word_t rot_r;
  logic  fill_l;
  logic  fill_r;

  // circular forms refill from the opposite end, carry forms from CY
  assign fill_l = (op_i == OP_RAL) ? cy_i : a_i[ACC_W-1];
  assign fill_r = (op_i == OP_RAR) ? cy_i : a_i[0];

  assign rot_l[0]       = fill_l;
  assign rot_r[ACC_W-1] = fill_r;
  for (genvar k = 1; k < ACC_W; k++) begin : g_shift
    assign rot_l[k]   = a_i[k-1];
    assign rot_r[k-1] = a_i[k];
  end

  always_comb begin
    res_o = a_i;
    cy_o  = cy_i;
    unique case (op_i)
      OP_AND: begin res_o = a_i & b_i; cy_o = 1'b0; end
      OP_XOR: begin res_o = a_i ^ b_i; cy_o = 1'b0; end
      OP_OR:  begin res_o = a_i | b_i; cy_o = 1'b0; end
      OP_RLC, OP_RAL: begin res_o = rot_l; cy_o = a_i[ACC_W-1]; end
      OP_RRC, OP_RAR: begin res_o = rot_r; cy_o = a_i[0]; end
      OP_CMA: res_o = ~a_i;
      OP_STC: cy_o = 1'b1;
      OP_CMC: cy_o = ~cy_i;
      default: begin res_o = a_i; cy_o = cy_i; end
    endcase
  end
endmodule

// File: rtl/alu_decadj.sv
module alu_decadj
  import acc_alu_pkg::*;
(
  input  word_t a_i,
  input  logic  ac_i,
  input  logic  cy_i,
  output word_t res_o,
  output logic  ac_o,
  output logic  cy_o
);
  localparam logic [ACC_W:0] LO_ADJ = {{(ACC_W-NIB_W+1){1'b0}}, DEC_STEP};
  localparam word_t          HI_ADJ = {DEC_STEP, {NIB_W{1'b0}}};

  nib_t           lo;
  logic           lo_fix;
  logic           hi_fix;
  logic [NIB_W:0] lo_probe;
  logic [ACC_W:0] stage1;

  assign lo       = a_i[NIB_W-1:0];
  assign lo_fix   = (lo > DEC_MAX) | ac_i;
  assign lo_probe = nib_sum(lo, DEC_STEP, 1'b0);
  assign stage1   = {1'b0, a_i} + (lo_fix ? LO_ADJ : '0);
  // high correction is judged on the byte after the low correction
  assign hi_fix   = (stage1[ACC_W-1:NIB_W] > DEC_MAX) | stage1[ACC_W] | cy_i;

  assign res_o = stage1[ACC_W-1:0] + (hi_fix ? HI_ADJ : '0);
  assign cy_o  = hi_fix;
  assign ac_o  = lo_fix & lo_probe[NIB_W];
endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
  import acc_alu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [OP_W-1:0]   op_code,
  input  logic [ACC_W-1:0]  operand,
  output logic [ACC_W-1:0]  acc_q,
  output logic [FLAG_W-1:0] flags_q
);
  op_e    op;
  word_t  acc_r;
  flags_t flg_r;
  word_t  acc_nxt;
  flags_t flg_nxt;

  // named events for the checker
  logic upd_en;
  logic sub_grp;
  logic use_cy;

  word_t as_res;
  logic  as_cy;
  logic  as_ac;
  word_t bw_res;
  logic  bw_cy;
  word_t da_res;
  logic  da_cy;
  logic  da_ac;

  assign op      = op_e'(op_code);
  assign upd_en  = op_valid;
  assign sub_grp = (op == OP_SUB) | (op == OP_SBB) | (op == OP_CMP);
  assign use_cy  = (op == OP_ADC) | (op == OP_SBB);

  alu_addsub u_addsub (
    .a_i      (acc_r),
    .b_i      (operand),
    .cy_i     (flg_r.cy),
    .sub_i    (sub_grp),
    .use_cy_i (use_cy),
    .res_o    (as_res),
    .cy_o     (as_cy),
    .ac_o     (as_ac)
  );

  alu_bitwise u_bitwise (
    .op_i  (op),
    .a_i   (acc_r),
    .b_i   (operand),
    .cy_i  (flg_r.cy),
    .res_o (bw_res),
    .cy_o  (bw_cy)
  );

  alu_decadj u_decadj (
    .a_i   (acc_r),
    .ac_i  (flg_r.ac),
    .cy_i  (flg_r.cy),
    .res_o (da_res),
    .ac_o  (da_ac),
    .cy_o  (da_cy)
  );

  always_comb begin
    acc_nxt = acc_r;
    flg_nxt = flg_r;
    unique case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
        acc_nxt = as_res;
        flg_nxt = eval_flags(as_res, as_ac, as_cy);
      end
      OP_CMP: flg_nxt = eval_flags(as_res, as_ac, as_cy);
      OP_AND: begin
        acc_nxt = bw_res;
        flg_nxt = eval_flags(bw_res, 1'b1, bw_cy);
      end
      OP_XOR, OP_OR: begin
        acc_nxt = bw_res;
        flg_nxt = eval_flags(bw_res, 1'b0, bw_cy);
      end
      OP_RLC, OP_RRC, OP_RAL, OP_RAR: begin
        acc_nxt    = bw_res;
        flg_nxt.cy = bw_cy;
      end
      OP_DAA: begin
        acc_nxt = da_res;
        flg_nxt = eval_flags(da_res, da_ac, da_cy);
      end
      OP_CMA: acc_nxt = bw_res;
      OP_STC, OP_CMC: flg_nxt.cy = bw_cy;
      default: begin
        acc_nxt = acc_r;
        flg_nxt = flg_r;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_r <= '0;
      flg_r <= '0;
    end else if (upd_en) begin
      acc_r <= acc_nxt;
      flg_r <= flg_nxt;
    end
  end

  assign acc_q   = acc_r;
  assign flags_q = flg_r;
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
  import acc_alu_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              upd_en,
  input logic [OP_W-1:0]   op_code,
  input logic [ACC_W-1:0]  acc_q,
  input logic [FLAG_W-1:0] flags_q
);
  localparam int F_CY = 0;
  localparam int F_P  = 1;
  localparam int F_AC = 2;
  localparam int F_Z  = 3;
  localparam int F_S  = 4;

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> $stable(acc_q) && $stable(flags_q));

  assert_szp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en && (op_code <= 4'd6 || op_code == 4'd12) |=>
      flags_q[F_S] == acc_q[ACC_W-1] && flags_q[F_Z] == (acc_q == '0) && flags_q[F_P] == ~^acc_q);

  assert_cmp_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en && op_code == 4'd7 |=> $stable(acc_q));

  assert_logic_cy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en && op_code >= 4'd4 && op_code <= 4'd6 |=>
      !flags_q[F_CY] && flags_q[F_AC] == ($past(op_code) == 4'd4));

  assert_rlc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en && op_code == 4'd8 |=> acc_q[0] == flags_q[F_CY] && flags_q[F_CY] == $past(acc_q[ACC_W-1]));

  assert_rrc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en && op_code == 4'd9 |=> acc_q[ACC_W-1] == flags_q[F_CY] && flags_q[F_CY] == $past(acc_q[0]));

  assert_ral_R9: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en && op_code == 4'd10 |=> acc_q[0] == $past(flags_q[F_CY]) && flags_q[F_CY] == $past(acc_q[ACC_W-1]));

  assert_rar_R9: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en && op_code == 4'd11 |=> acc_q[ACC_W-1] == $past(flags_q[F_CY]) && flags_q[F_CY] == $past(acc_q[0]));

  assert_rot_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en && op_code[3:2] == 2'b10 |=> flags_q[FLAG_W-1:1] == $past(flags_q[FLAG_W-1:1]));

  assert_daa_cy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en && op_code == 4'd12 && flags_q[F_CY] |=> flags_q[F_CY]);

  assert_cma_R12: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en && op_code == 4'd13 |=> acc_q == ~$past(acc_q) && $stable(flags_q));

  assert_stc_R12: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en && op_code == 4'd14 |=> flags_q[F_CY] && $stable(acc_q) && $stable(flags_q[FLAG_W-1:1]));

  assert_cmc_R12: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en && op_code == 4'd15 |=> flags_q[F_CY] != $past(flags_q[F_CY]) && $stable(acc_q));
endmodule

bind acc_alu_core acc_alu_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .upd_en  (upd_en),
  .op_code (op_code),
  .acc_q   (acc_q),
  .flags_q (flags_q)
);

// File: tb/acc_alu_core_tb_top.sv
module acc_alu_core_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [3:0] op_code = 4'd0;
  logic [7:0] operand = 8'd0;
  logic [7:0] acc_q;
  logic [4:0] flags_q;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  localparam int ADD = 0, ADC = 1, SUB = 2, SBB = 3, AND_ = 4, XOR_ = 5, OR_ = 6, CMP = 7;
  localparam int RLC = 8, RRC = 9, RAL = 10, RAR = 11, DAA = 12, CMA = 13, STC = 14, CMC = 15;

  always #5 clk = ~clk;

  acc_alu_core dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_code  (op_code),
    .operand  (operand),
    .acc_q    (acc_q),
    .flags_q  (flags_q)
  );

  // reference state
  int m_acc = 0;
  bit ms = 0, mz = 0, mac = 0, mp = 0, mcy = 0;

  function automatic void set_szp(int r);
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += (r >> i) & 1;
    ms = (r >= 128);
    mz = (r == 0);
    mp = (ones % 2 == 0);
  endfunction

  function automatic string req_of(int op);
    case (op)
      ADD, ADC: return "R3";
      SUB, SBB: return "R4";
      CMP: return "R6";
      AND_, XOR_, OR_: return "R7";
      RLC, RRC: return "R8/R10";
      RAL, RAR: return "R9/R10";
      DAA: return "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic model_step(int op, int b);
    int t, ci, lo, hi, corr;
    bit nac, ncy;
    case (op)
      ADD, ADC: begin
        ci = (op == ADC) ? int'(mcy) : 0;
        t = m_acc + b + ci;
        mac = ((m_acc % 16) + (b % 16) + ci) > 15;
        mcy = t > 255;
        m_acc = t % 256;
        set_szp(m_acc);
      end
      SUB, SBB, CMP: begin
        ci = (op == SBB) ? int'(mcy) : 0;
        t = m_acc - b - ci;
        mac = ((m_acc % 16) - (b % 16) - ci) < 0;
        mcy = t < 0;
        set_szp((t + 256) % 256);
        if (op != CMP) m_acc = (t + 256) % 256;
      end
      AND_: begin m_acc = m_acc & b; mac = 1; mcy = 0; set_szp(m_acc); end
      XOR_: begin m_acc = m_acc ^ b; mac = 0; mcy = 0; set_szp(m_acc); end
      OR_:  begin m_acc = m_acc | b; mac = 0; mcy = 0; set_szp(m_acc); end
      RLC: begin hi = m_acc / 128; m_acc = (m_acc * 2) % 256 + hi; mcy = hi[0]; end
      RRC: begin lo = m_acc % 2; m_acc = m_acc / 2 + lo * 128; mcy = lo[0]; end
      RAL: begin hi = m_acc / 128; m_acc = (m_acc * 2) % 256 + int'(mcy); mcy = hi[0]; end
      RAR: begin lo = m_acc % 2; m_acc = m_acc / 2 + int'(mcy) * 128; mcy = lo[0]; end
      DAA: begin
        corr = 0;
        nac = (m_acc % 16) > 9;
        if ((m_acc % 16) > 9 || mac) corr += 6;
        ncy = (m_acc > 153) || mcy;
        if (ncy) corr += 96;
        m_acc = (m_acc + corr) % 256;
        mac = nac;
        mcy = ncy;
        set_szp(m_acc);
      end
      CMA: m_acc = 255 - m_acc;
      STC: mcy = 1;
      default: mcy = !mcy;
    endcase
  endtask

  task automatic check(string tag);
    logic [4:0] ef;
    ef = {ms, mz, mac, mp, mcy};
    n_cmp++;
    if (acc_q !== m_acc[7:0] || flags_q !== ef) begin
      n_bad++;
      $display("FAIL %s (flags R5): acc=%02h flags=%05b expected acc=%02h flags=%05b",
               tag, acc_q, flags_q, m_acc[7:0], ef);
    end
  endtask

  // drive at a falling edge, captured on the next rising edge, checked one falling edge later
  task automatic apply(int op, int b);
    op_valid = 1'b1;
    op_code  = op[3:0];
    operand  = b[7:0];
    model_step(op, b);
    @(negedge clk);
    op_valid = 1'b0;
    check(req_of(op));
  endtask

  int bv[5] = '{0, 60, 127, 154, 255};

  initial begin
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1");

    // R2: strobe low, busy inputs, nothing moves
    apply(OR_, 8'h5A);
    apply(STC, 0);
    op_valid = 1'b0;
    op_code  = 4'd0;
    operand  = 8'hFF;
    repeat (3) @(negedge clk);
    check("R2");
    op_code = 4'd13;
    repeat (2) @(negedge clk);
    check("R2");

    // every operation over every accumulator value with four AC/CY states
    for (int op = 0; op < 16; op++) begin
      for (int a = 0; a < 256; a++) begin
        for (int j = 0; j < 5; j++) begin
          apply(AND_, 0);
          apply(OR_, a);
          if (j[0]) apply(AND_, 255);
          if (j[1]) apply(STC, 0);
          apply(op, bv[j]);
        end
      end
    end

    // R11: decimal correction after a carry-in add of many byte pairs
    for (int x = 0; x < 256; x++) begin
      for (int y = 0; y < 256; y += 7) begin
        apply(AND_, 0);
        apply(OR_, x);
        if (y[0]) apply(STC, 0);
        apply(ADC, y);
        apply(DAA, 0);
      end
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog R2: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule